// File: doc/BRIEF.md
# Iterative Midpoint-and-Quadruple Unit

This block takes an 8-bit unsigned operand X and an 8-bit two's-complement operand Y. It returns, on an 8-bit output Z, four times a value formed from them. When X is at least the magnitude of Y, that value is X itself. Otherwise it is the rounded-up midpoint of X and |Y|. The block has no adder-based averaging and no multiplier. It takes the magnitude of Y, then walks the two working values toward each other, one step per iteration, until the lower one has caught up. The result is then quadrupled by two single-bit left shifts in the output register.

A nine-state one-hot controller sequences the datapath. Operation is a simple request/complete handshake. While idle the block holds `done` high. A cycle with `start` high starts a run, and `done` falls. `done` rises again in the same edge that leaves the final value on Z. Z then holds until the next run finishes.

Top module: `avg_scale_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the unit returns to idle with `done` = 1 and `z` = 0, including in the middle of a run.
- R2: In idle, `start` sampled high at a rising edge accepts a run. `done` is still 1 after that edge and reads 0 after the next one.
- R3: X and Y are captured only in the cycle after acceptance. Changes to `x`, `y` and pulses of `start` while a run is in progress do not affect that run's result or latency.
- R4: Y is two's complement, with bit 7 as the sign. When bit 7 is set, the magnitude |Y| = (256 − Y) is used, so Y = 0x80 gives |Y| = 128.
- R5: When X ≥ |Y| (unsigned compare), the final Z is (4·X) mod 256.
- R6: When X < |Y|, the final Z is (4·ceil((X+|Y|)/2)) mod 256. This value is reached by ceil((|Y|−X)/2) iterations, each adding one to the low working value and subtracting one from the high one.
- R7: Counting rising edges after the accepting edge, `done` reads 1 again after exactly 6 + s + 2·n edges. Here s = 1 when Y is negative (else 0) and n is the iteration count of R6 (0 under R5).
- R8: While `done` stays high, `z` does not change, whatever `x` and `y` do.
- R9: Exactly one controller state is active in every cycle out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request, sampled while idle |
| x | input | 8 | Unsigned operand |
| y | input | 8 | Two's-complement operand |
| z | output | 8 | Quadrupled result, low 8 bits |
| done | output | 1 | High while idle; rises when Z is final |

## Verification
The hardest case to reach is the longest iteration path. It needs X = 0 with Y = −128, where the negation step produces 0x80 and the loop then runs 64 times. A second long case is Y = 127, which reaches the same midpoint without negation. Both cases sit in the directed vector table, together with differences of 0 and 1 that exercise the loop exit when the working values meet or cross. Interference from inputs during a run is reached by toggling `x`, `y` and `start` at a fixed cycle inside a 14-cycle run. A few hundred random operand pairs then check value and latency against a model computed from the requirements.

// File: rtl/avg_scale_pkg.sv
package avg_scale_pkg;

    localparam int NUM_ST = 9;

    // bit position of each state inside the one-hot vector
    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_LOAD = 4'd1,
        ST_SIGN = 4'd2,
        ST_NEG  = 4'd3,
        ST_CMP  = 4'd4,
        ST_STEP = 4'd5,
        ST_XFER = 4'd6,
        ST_SH1  = 4'd7,
        ST_SH2  = 4'd8
    } st_idx_e;

    typedef logic [NUM_ST-1:0] st_vec_t;

    // controls carried from sequencer to datapath
    typedef struct packed {
        logic ld_ops;
        logic neg_b;
        logic step;
        logic z_load;
        logic z_shift;
        logic done_set;
        logic done_clr;
    } ctl_t;

    // condition flags carried from datapath to sequencer
    typedef struct packed {
        logic b_neg;
        logic a_ge_b;
    } cond_t;

    function automatic st_vec_t st_bit(input st_idx_e idx);
        st_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/avg_scale_ctrl.sv
module avg_scale_ctrl
    import avg_scale_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  cond_t   cond,
    output ctl_t    ctl,
    output st_vec_t st_q,
    output logic    done_q
);
    localparam st_vec_t ST_RESET = st_bit(ST_IDLE);

    st_vec_t st_d;

    // each next-state bit gathers all inward edges of that state
    always_comb begin
        st_d          = '0;
        st_d[ST_IDLE] = (st_q[ST_IDLE] & ~start) | st_q[ST_SH2];
        st_d[ST_LOAD] = st_q[ST_IDLE] & start;
        st_d[ST_SIGN] = st_q[ST_LOAD];
        st_d[ST_NEG]  = st_q[ST_SIGN] & cond.b_neg;
        st_d[ST_CMP]  = (st_q[ST_SIGN] & ~cond.b_neg) | st_q[ST_NEG] | st_q[ST_STEP];
        st_d[ST_STEP] = st_q[ST_CMP] & ~cond.a_ge_b;
        st_d[ST_XFER] = st_q[ST_CMP] & cond.a_ge_b;
        st_d[ST_SH1]  = st_q[ST_XFER];
        st_d[ST_SH2]  = st_q[ST_SH1];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_RESET;
        else     st_q <= st_d;
    end

    // control decode straight from the state bits
    always_comb begin
        ctl.ld_ops   = st_q[ST_LOAD];
        ctl.done_clr = st_q[ST_LOAD];
        ctl.neg_b    = st_q[ST_NEG];
        ctl.step     = st_q[ST_STEP];
        ctl.z_load   = st_q[ST_XFER];
        ctl.z_shift  = st_q[ST_SH1] | st_q[ST_SH2];
        ctl.done_set = st_q[ST_SH2];
    end

    always_ff @(posedge clk) begin
        if (rst)               done_q <= 1'b1;
        else if (ctl.done_set) done_q <= 1'b1;
        else if (ctl.done_clr) done_q <= 1'b0;
    end

endmodule

// File: rtl/avg_scale_ops.sv
module avg_scale_ops
    import avg_scale_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  ctl_t         ctl,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] a_q,
    output logic [W-1:0] b_q,
    output cond_t        cond
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] a_d;
    logic [W-1:0] b_d;

    always_comb begin
        a_d = a_q;
        b_d = b_q;
        if (ctl.ld_ops) begin
            a_d = x;
            b_d = y;
        end else if (ctl.neg_b) begin
            b_d = ~b_q + ONE;
        end else if (ctl.step) begin
            a_d = a_q + ONE;
            b_d = b_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            a_q <= a_d;
            b_q <= b_d;
        end
    end

    // unsigned compare and sign tap for the sequencer
    assign cond.a_ge_b = (a_q >= b_q);
    assign cond.b_neg  = b_q[W-1];

endmodule

// File: rtl/avg_scale_outreg.sv
module avg_scale_outreg
    import avg_scale_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  ctl_t         ctl,
    input  logic [W-1:0] a,
    output logic [W-1:0] z_q
);
    logic [W-1:0] z_d;

    // per-bit source: parallel load, left neighbour on shift, else hold
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            always_comb begin
                if (ctl.z_load)       z_d[i] = a[i];
                else if (ctl.z_shift) z_d[i] = 1'b0;
                else                  z_d[i] = z_q[i];
            end
        end else begin : g_upper
            always_comb begin
                if (ctl.z_load)       z_d[i] = a[i];
                else if (ctl.z_shift) z_d[i] = z_q[i-1];
                else                  z_d[i] = z_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) z_q <= '0;
        else     z_q <= z_d;
    end

endmodule

// File: rtl/avg_scale_unit.sv
module avg_scale_unit
    import avg_scale_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] z,
    output logic         done
);
    ctl_t         ctl;
    cond_t        cond;
    st_vec_t      st_vec;
    logic [W-1:0] a_val;
    logic [W-1:0] b_val;

    avg_scale_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cond   (cond),
        .ctl    (ctl),
        .st_q   (st_vec),
        .done_q (done)
    );

    avg_scale_ops #(.W(W)) u_ops (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .x    (x),
        .y    (y),
        .a_q  (a_val),
        .b_q  (b_val),
        .cond (cond)
    );

    avg_scale_outreg #(.W(W)) u_out (
        .clk (clk),
        .rst (rst),
        .ctl (ctl),
        .a   (a_val),
        .z_q (z)
    );

endmodule

// File: rtl/avg_scale_unit_chk.sv
module avg_scale_unit_chk
    import avg_scale_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         done,
    input logic [W-1:0] z,
    input st_vec_t      st,
    input logic [W-1:0] a,
    input logic [W-1:0] b
);
    // R9: one active state
    a_r9_onehot_state: assert property (@(posedge clk) disable iff (rst)
        $countones(st) == 1);

    // R2: done only drops two edges after a sampled start
    a_r2_done_drop_after_start: assert property (@(posedge clk) disable iff (rst)
        $fell(done) |-> $past(start, 2));

    // R8: output frozen while done stays high
    a_r8_z_held_while_done: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> $stable(z));

    // R5: final value is a multiple of four
    a_r5_scaled_by_four: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (z[1:0] == 2'b00));

    // R6: an iteration only runs while the low value is below the high one
    a_r6_step_only_below: assert property (@(posedge clk) disable iff (rst)
        st[ST_STEP] |-> (a < b));

    // R6: an iteration moves both working values by one
    a_r6_step_moves_both: assert property (@(posedge clk) disable iff (rst)
        st[ST_STEP] |=> ((a == W'($past(a) + W'(1))) && (b == W'($past(b) - W'(1)))));

    // R4: after negation the high value is a magnitude
    a_r4_neg_gives_magnitude: assert property (@(posedge clk) disable iff (rst)
        st[ST_NEG] |=> (!b[W-1] || (b == {1'b1, {(W-1){1'b0}}})));

endmodule

bind avg_scale_unit avg_scale_unit_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .done  (done),
    .z     (z),
    .st    (st_vec),
    .a     (a_val),
    .b     (b_val)
);

// File: tb/avg_scale_unit_bench.sv
module avg_scale_unit_bench;

    localparam int NV = 14;
    localparam int TMO = 1000;

    // {x, y, expected z}
    localparam logic [23:0] VEC [NV] = '{
        {8'd10,  8'd3,   8'h28},
        {8'd3,   8'd10,  8'h1C},
        {8'd0,   8'd0,   8'h00},
        {8'd5,   8'd0,   8'h14},
        {8'd0,   8'd1,   8'h04},
        {8'd4,   8'hFA,  8'h14},
        {8'd0,   8'h80,  8'h00},
        {8'd64,  8'd0,   8'h00},
        {8'd255, 8'd127, 8'hFC},
        {8'd0,   8'd127, 8'h00},
        {8'd100, 8'hFF,  8'h90},
        {8'd7,   8'd7,   8'h1C},
        {8'd1,   8'h9C,  8'hCC},
        {8'd20,  8'd30,  8'h64}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] x = '0;
    logic [7:0] y = '0;
    logic [7:0] z;
    logic       done;

    int n_run = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    avg_scale_unit u_avg_scale_unit (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .x     (x),
        .y     (y),
        .z     (z),
        .done  (done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // model from R4..R7
    task automatic model(input logic [7:0] mx, input logic [7:0] my,
                         output int mz, output int mlat);
        int mag, av, n, s;
        s   = my[7] ? 1 : 0;
        mag = my[7] ? (256 - int'(my)) : int'(my);
        if (int'(mx) >= mag) begin
            av = mx; n = 0;
        end else begin
            av = (int'(mx) + mag + 1) / 2;
            n  = (mag - int'(mx) + 1) / 2;
        end
        mz   = (4 * av) % 256;
        mlat = 6 + s + 2 * n;
    endtask

    task automatic run_op(input logic [7:0] rx, input logic [7:0] ry,
                          input bit disturb, output int rz, output int rlat);
        int cnt;
        @(negedge clk);
        x = rx; y = ry; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 done held in accept cycle", int'(done), 1);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) check("R2 done low after accept", int'(done), 0);
            if (disturb && cnt == 3) begin
                x = ~rx; y = 8'hCE; start = 1'b1;
            end
            if (disturb && cnt == 4) start = 1'b0;
        end while (!done && cnt < TMO);
        if (cnt >= TMO) check("R7 run timed out", 0, 1);
        rz = z;
        rlat = cnt;
    endtask

    initial begin
        int gz, glat, ez, elat;
        logic [7:0] hz;

        repeat (3) @(negedge clk);
        check("R1 reset done", int'(done), 1);
        check("R1 reset z", int'(z), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 idle done", int'(done), 1);

        // table walk: R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][23:16], VEC[i][15:8], 1'b0, gz, glat);
            model(VEC[i][23:16], VEC[i][15:8], ez, elat);
            check("R5/R6 table z", gz, int'(VEC[i][7:0]));
            check("R7 table latency", glat, elat);
        end

        // R3: inputs and start toggled during a run
        run_op(8'd3, 8'd10, 1'b1, gz, glat);
        check("R3 result unaffected", gz, 28);
        check("R3 latency unaffected", glat, 14);

        // R8: hold while idle
        hz = z;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            x = 8'(k * 37); y = 8'(k * 91);
        end
        check("R8 z held", int'(z), int'(hz));
        check("R8 done held", int'(done), 1);

        // R4: most negative operand against nonzero X
        run_op(8'd2, 8'h80, 1'b0, gz, glat);
        check("R4 y=-128 z", gz, (4 * 65) % 256);
        check("R4 y=-128 latency", glat, 6 + 1 + 2 * 63);

        // random pairs: R5 R6 R7
        for (int i = 0; i < 300; i++) begin
            logic [7:0] rx, ry;
            rx = 8'($urandom);
            ry = 8'($urandom);
            run_op(rx, ry, 1'b0, gz, glat);
            model(rx, ry, ez, elat);
            check("R5/R6 random z", gz, ez);
            check("R7 random latency", glat, elat);
        end

        // R1: reset in mid-run
        @(negedge clk);
        x = 8'd0; y = 8'h80; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        check("R1 busy before reset", int'(done), 0);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset done", int'(done), 1);
        check("R1 mid-run reset z", int'(z), 0);
        rst = 1'b0;
        @(negedge clk);
        run_op(8'd5, 8'd0, 1'b0, gz, glat);
        check("R1 run after reset", gz, 20);

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        #(20 * 190000);
        n_run++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule